// File: doc/BRIEF.md
# Source-Port Distributor with Class Counters

This block maps each incoming packet to a destination port and a traffic class. A packet arrives with a source port number, the class bits carried in its status word and a byte length. The source port indexes a configuration table with one entry per source. Each entry names the destination port and holds a selector flag. The flag decides whether the class comes from the status word or from a class stored in the entry. The mapped destination and class appear on registered outputs one cycle after the packet is presented.

For every pair of destination port and class the block keeps a packet counter and a byte counter. Software reaches the table, both counter banks and a read-only initialisation flag through one register port. Writes are synchronous and reads are combinational. After reset a sweep clears one counter index per cycle and then raises the done flag. Packets that arrive before that point are still mapped but are not counted.

Register port address `sw_addr[9:0]`: bits 9:8 select a region (0 table, 1 packet counters, 2 byte counters, 3 done flag). Bits 7:0 give the table index and bits 3:0 give the counter index.

Top module: `pdist_top`

## Requirements
- R1: After reset, `out_valid` is 0, every table entry reads 0 and the done flag (region 3, bit 0) reads 0.
- R2: A write to region 0 stores `sw_wdata[4:0]` into the entry selected by `sw_addr[7:0]`. A read of that entry returns those bits, with bits 31:5 reading 0.
- R3: One cycle after a cycle with `pkt_valid` high, `out_valid` is 1 and `out_dst` equals bits 1:0 of the entry addressed by `pkt_src`. In a cycle after one with `pkt_valid` low, `out_valid` is 0.
- R4: If bit 2 of the entry is 0, `out_tc` equals the `pkt_stat_tc` that was presented. If bit 2 is 1, `out_tc` equals bits 4:3 of the entry.
- R5: A counted packet updates counter index 4*dst+tc, using the mapped destination and class. Packet counters are read and written in region 1 and byte counters in region 2, with the index in `sw_addr[3:0]`.
- R6: Each counted packet adds 1 to its packet counter and `pkt_len` to its byte counter. Both updates are visible from the clock edge that samples the packet.
- R7: Both counters wrap to the low bits of the sum on overflow.
- R8: When a software write and a packet hit the same counter in one cycle, the written value is kept. The other bank's counter for that packet still increments.
- R9: After reset is released, the done flag rises within 24 cycles and then stays at 1.
- R10: A packet accepted before the done flag is set is mapped on the outputs but leaves all counters at 0.
- R11: Writes to region 3 have no effect, and the done flag keeps reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_src | input | 8 | Source port number |
| pkt_stat_tc | input | 2 | Class bits from the status word |
| pkt_len | input | 16 | Packet length in bytes |
| out_valid | output | 1 | Registered mapping valid |
| out_dst | output | 2 | Registered destination port |
| out_tc | output | 2 | Registered traffic class |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 10 | Register address (region and index) |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Combinational register read data |

## Verification
A corrupted table entry shows on `out_dst` or `out_tc` in the cycle after the first packet from that source. It also shows on an immediate software read of that entry. A wrong counter index or increment is not seen on the outputs. It appears only when software reads the counter, so every packet test ends with a read of the expected index and of a neighbouring index. A stuck or early initialisation sweep shows as a done flag that fails to rise within its window, or as counts taken from packets that should have been skipped.

// File: rtl/pdist_pkg.sv
package pdist_pkg;
  localparam int SRC_W = 8;
  localparam int DST_W = 2;
  localparam int TC_W  = 2;
  localparam int CNT_W = 32;
  localparam int LEN_W = 16;
  localparam int ENT_W = DST_W + 1 + TC_W;
  localparam int CIX_W = DST_W + TC_W;

  typedef enum logic [1:0] {
    RG_TABLE = 2'd0,
    RG_PKT   = 2'd1,
    RG_BYTE  = 2'd2,
    RG_DONE  = 2'd3
  } region_e;
endpackage

// File: rtl/pdist_map_table.sv
module pdist_map_table #(
  parameter int IDX_W = 8,
  parameter int EW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [EW-1:0]    wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [EW-1:0]    rd_entry,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [EW-1:0]    lk_entry
);
  localparam int NENT = 1 << IDX_W;

  logic [EW-1:0] tbl_q [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl_q[i] <= '0;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_entry;
    end
  end

  assign rd_entry = tbl_q[rd_idx];
  assign lk_entry = tbl_q[lk_idx];

  // R2: a written entry is visible at the next cycle
  p_table_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/pdist_cnt_bank.sv
module pdist_cnt_bank #(
  parameter int NCNT  = 16,
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [$clog2(NCNT)-1:0] inc_idx,
  input  logic [LEN_W-1:0] inc_len,
  input  logic             wr_pkt,
  input  logic             wr_byte,
  input  logic [$clog2(NCNT)-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [$clog2(NCNT)-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_pkt,
  output logic [CNT_W-1:0] rd_byte,
  output logic             init_done
);
  localparam int IW = $clog2(NCNT);
  localparam logic [IW-1:0] LAST_IDX = IW'(NCNT - 1);

  logic [CNT_W-1:0] pkt_q  [NCNT];
  logic [CNT_W-1:0] byte_q [NCNT];
  logic [CNT_W-1:0] pkt_d  [NCNT];
  logic [CNT_W-1:0] byte_d [NCNT];
  logic [NCNT-1:0]  pkt_en, byte_en;
  logic [IW-1:0]    init_idx_q, init_idx_d;
  logic             done_q, done_d;
  logic             hw_ok;

  assign hw_ok = inc_en && done_q;

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      pkt_d[i]   = pkt_q[i];
      byte_d[i]  = byte_q[i];
      pkt_en[i]  = 1'b0;
      byte_en[i] = 1'b0;
      if (!done_q && init_idx_q == IW'(i)) begin
        pkt_d[i]   = '0;
        byte_d[i]  = '0;
        pkt_en[i]  = 1'b1;
        byte_en[i] = 1'b1;
      end else begin
        if (wr_pkt && wr_idx == IW'(i)) begin
          pkt_d[i]  = wr_data;
          pkt_en[i] = 1'b1;
        end else if (hw_ok && inc_idx == IW'(i)) begin
          pkt_d[i]  = pkt_q[i] + CNT_W'(1);
          pkt_en[i] = 1'b1;
        end
        if (wr_byte && wr_idx == IW'(i)) begin
          byte_d[i]  = wr_data;
          byte_en[i] = 1'b1;
        end else if (hw_ok && inc_idx == IW'(i)) begin
          byte_d[i]  = byte_q[i] + CNT_W'(inc_len);
          byte_en[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    init_idx_d = init_idx_q;
    done_d     = done_q;
    if (!done_q) begin
      init_idx_d = init_idx_q + IW'(1);
      if (init_idx_q == LAST_IDX) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) begin
        pkt_q[i]  <= '0;
        byte_q[i] <= '0;
      end
      init_idx_q <= '0;
      done_q     <= 1'b0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (pkt_en[i])  pkt_q[i]  <= pkt_d[i];
        if (byte_en[i]) byte_q[i] <= byte_d[i];
      end
      init_idx_q <= init_idx_d;
      done_q     <= done_d;
    end
  end

  assign rd_pkt    = pkt_q[rd_idx];
  assign rd_byte   = byte_q[rd_idx];
  assign init_done = done_q;

  // R9: once set, the done flag holds
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R10: the sweep leaves the swept index at zero
  p_sweep_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> pkt_q[$past(init_idx_q)] == '0 && byte_q[$past(init_idx_q)] == '0);

  // R6: an uncontested counted packet adds exactly one
  p_pkt_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_ok && !(wr_pkt && wr_idx == inc_idx)) |=>
      pkt_q[$past(inc_idx)] == $past(pkt_q[inc_idx]) + CNT_W'(1));

  // R8: a software write wins over a packet on the same counter
  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && wr_pkt) |=> pkt_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/pdist_top.sv
module pdist_top
  import pdist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [SRC_W-1:0] pkt_src,
  input  logic [TC_W-1:0]  pkt_stat_tc,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             out_valid,
  output logic [DST_W-1:0] out_dst,
  output logic [TC_W-1:0]  out_tc,
  input  logic             sw_we,
  input  logic [SRC_W+1:0] sw_addr,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata
);
  localparam int NCNT = 1 << CIX_W;

  logic       rs_meta, rs_n;
  region_e    region;
  logic [SRC_W-1:0] sw_idx;
  logic [ENT_W-1:0] rd_entry, lk_entry;
  logic [DST_W-1:0] map_dst;
  logic [TC_W-1:0]  map_tc;
  logic [CIX_W-1:0] map_cix;
  logic [CNT_W-1:0] rd_pkt, rd_byte;
  logic             init_done;
  logic             ov_d;
  logic [DST_W-1:0] od_d;
  logic [TC_W-1:0]  ot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign region = region_e'(sw_addr[SRC_W+1:SRC_W]);
  assign sw_idx = sw_addr[SRC_W-1:0];

  pdist_map_table #(.IDX_W(SRC_W), .EW(ENT_W)) table_i (
    .clk      (clk),
    .rst_n    (rs_n),
    .wr_en    (sw_we && region == RG_TABLE),
    .wr_idx   (sw_idx),
    .wr_entry (sw_wdata[ENT_W-1:0]),
    .rd_idx   (sw_idx),
    .rd_entry (rd_entry),
    .lk_idx   (pkt_src),
    .lk_entry (lk_entry)
  );

  assign map_dst = lk_entry[DST_W-1:0];
  assign map_tc  = lk_entry[DST_W] ? lk_entry[ENT_W-1:DST_W+1] : pkt_stat_tc;
  assign map_cix = {map_dst, map_tc};

  pdist_cnt_bank #(.NCNT(NCNT), .CNT_W(CNT_W), .LEN_W(LEN_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rs_n),
    .inc_en    (pkt_valid),
    .inc_idx   (map_cix),
    .inc_len   (pkt_len),
    .wr_pkt    (sw_we && region == RG_PKT),
    .wr_byte   (sw_we && region == RG_BYTE),
    .wr_idx    (sw_idx[CIX_W-1:0]),
    .wr_data   (sw_wdata[CNT_W-1:0]),
    .rd_idx    (sw_idx[CIX_W-1:0]),
    .rd_pkt    (rd_pkt),
    .rd_byte   (rd_byte),
    .init_done (init_done)
  );

  always_comb begin
    sw_rdata = '0;
    unique case (region)
      RG_TABLE: sw_rdata[ENT_W-1:0] = rd_entry;
      RG_PKT:   sw_rdata[CNT_W-1:0] = rd_pkt;
      RG_BYTE:  sw_rdata[CNT_W-1:0] = rd_byte;
      RG_DONE:  sw_rdata[0]         = init_done;
      default:  sw_rdata            = '0;
    endcase
  end

  always_comb begin
    ov_d = pkt_valid;
    od_d = out_dst;
    ot_d = out_tc;
    if (pkt_valid) begin
      od_d = map_dst;
      ot_d = map_tc;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
      out_tc    <= '0;
    end else begin
      out_valid <= ov_d;
      out_dst   <= od_d;
      out_tc    <= ot_d;
    end
  end

  // R3: a mapped output only follows a presented packet
  p_out_follows_r3: assert property (@(posedge clk) disable iff (!rs_n)
    out_valid |-> $past(pkt_valid));

  // R4: status-word class passes through when the entry flag is clear
  p_stat_tc_r4: assert property (@(posedge clk) disable iff (!rs_n)
    (pkt_valid && !lk_entry[DST_W]) |=> out_tc == $past(pkt_stat_tc));
endmodule

// File: tb/pdist_top_tb_top.sv
module pdist_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        pkt_valid;
  logic [7:0]  pkt_src;
  logic [1:0]  pkt_stat_tc;
  logic [15:0] pkt_len;
  logic        out_valid;
  logic [1:0]  out_dst;
  logic [1:0]  out_tc;
  logic        sw_we;
  logic [9:0]  sw_addr;
  logic [31:0] sw_wdata;
  logic [31:0] sw_rdata;

  int checks = 0;
  int errors = 0;

  pdist_top dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_src(pkt_src),
    .pkt_stat_tc(pkt_stat_tc), .pkt_len(pkt_len), .out_valid(out_valid),
    .out_dst(out_dst), .out_tc(out_tc), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] a_tbl(input int idx);
    return {2'd0, 8'(idx)};
  endfunction
  function automatic logic [9:0] a_pkt(input int dst, input int tc);
    return {2'd1, 4'd0, 2'(dst), 2'(tc)};
  endfunction
  function automatic logic [9:0] a_byt(input int dst, input int tc);
    return {2'd2, 4'd0, 2'(dst), 2'(tc)};
  endfunction
  localparam logic [9:0] A_DONE = {2'd3, 8'd0};

  task automatic sw_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    sw_addr = a;
    #1 d = sw_rdata;
  endtask

  task automatic send(input int src, input int tc, input int len);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_src = 8'(src); pkt_stat_tc = 2'(tc); pkt_len = 16'(len);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_src = '0; pkt_stat_tc = '0;
    pkt_len = '0; sw_we = 1'b0; sw_addr = '0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_and_init();
    logic [31:0] d;
    int waited;
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 0);
    sw_read(a_tbl(5), d);   check("R1 table entry", d, 0);
    sw_read(A_DONE, d);     check("R1 done", d, 0);
    send(5, 3, 64);
    check("R10 mapped valid", 32'(out_valid), 1);
    check("R10 mapped dst", 32'(out_dst), 0);
    check("R10 mapped tc", 32'(out_tc), 3);
    waited = 0;
    d = 0;
    while (d[0] !== 1'b1 && waited < 24) begin
      sw_read(A_DONE, d);
      waited++;
    end
    check("R9 done rises", d, 1);
    repeat (4) @(negedge clk);
    sw_read(A_DONE, d);     check("R9 done holds", d, 1);
    sw_read(a_pkt(0, 3), d); check("R10 pkt count untouched", d, 0);
    sw_read(a_byt(0, 3), d); check("R10 byte count untouched", d, 0);
  endtask

  task automatic t_table_rw();
    logic [31:0] d;
    sw_write(a_tbl(200), 32'hFFFF_FFF6);
    sw_read(a_tbl(200), d); check("R2 entry low bits, high zero", d, 32'h16);
    sw_read(a_tbl(201), d); check("R2 neighbour untouched", d, 0);
  endtask

  task automatic t_map();
    // entry 7: dst 2, flag 0; entry 9: dst 3, flag 1, tc 1
    sw_write(a_tbl(7), 32'h02);
    sw_write(a_tbl(9), 32'h0F);
    send(7, 1, 10);
    check("R3 dst", 32'(out_dst), 2);
    check("R4 status tc", 32'(out_tc), 1);
    send(9, 2, 20);
    check("R3 valid", 32'(out_valid), 1);
    check("R3 dst table", 32'(out_dst), 3);
    check("R4 table tc", 32'(out_tc), 1);
    @(negedge clk);
    check("R3 valid drops", 32'(out_valid), 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    // after t_map: idx (2,1) has 1 pkt/10 bytes; idx (3,1) has 1 pkt/20 bytes
    send(7, 1, 30);
    sw_read(a_pkt(2, 1), d); check("R6 pkt count", d, 2);
    sw_read(a_byt(2, 1), d); check("R6 byte count", d, 40);
    sw_read(a_pkt(3, 1), d); check("R5 other index pkt", d, 1);
    sw_read(a_byt(3, 1), d); check("R5 other index byte", d, 20);
    sw_read(a_pkt(2, 0), d); check("R5 neighbour zero", d, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    sw_write(a_pkt(2, 1), 32'hFFFF_FFFF);
    sw_write(a_byt(2, 1), 32'hFFFF_FFF0);
    send(7, 1, 32'h20);
    sw_read(a_pkt(2, 1), d); check("R7 pkt wrap", d, 0);
    sw_read(a_byt(2, 1), d); check("R7 byte wrap", d, 32'h10);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    sw_write(a_pkt(3, 1), 32'd50);
    sw_write(a_byt(3, 1), 32'd500);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_src = 8'd9; pkt_stat_tc = 2'd0; pkt_len = 16'd7;
    sw_we = 1'b1; sw_addr = a_pkt(3, 1); sw_wdata = 32'd100;
    @(negedge clk);
    pkt_valid = 1'b0; sw_we = 1'b0;
    sw_read(a_pkt(3, 1), d); check("R8 write kept", d, 100);
    sw_read(a_byt(3, 1), d); check("R8 byte still counts", d, 507);
  endtask

  task automatic t_done_ro();
    logic [31:0] d;
    sw_write(A_DONE, 32'h0);
    sw_read(A_DONE, d); check("R11 done read-only", d, 1);
  endtask

  initial begin
    apply_reset();
    t_reset_and_init();
    t_table_rw();
    t_map();
    t_count();
    t_wrap();
    t_priority();
    t_done_ro();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule